// File: doc/BRIEF.md
# Descriptor ring copy engine

A single-channel engine that drains a ring of source descriptors and fills a ring of empty destination buffers. Software fills source descriptors and moves the source write index. A second producer posts empty destination buffers, each with a byte count of zero, and moves the destination write index. The engine fetches each source descriptor and copies the buffer it references, one 32-bit word at a time, into the current destination buffer. It then writes the byte total and the flags back into the destination descriptor and advances its two read indices, which stay visible at the ports.

Source descriptors marked as gather are chained. Their data is concatenated into one destination buffer, and only the first descriptor in the chain without the gather mark closes the transfer and raises a single completion. A per-engine length cap clips oversized source descriptors. Byte swapping can be applied to the payload for each descriptor, and to descriptor fetches separately for each ring. All addresses are word addresses on a synchronous single-port memory, with read data returned one cycle after the request.

Top module: `ring_copy_engine`

## Requirements
- R1: After reset both read indices are 0, `done_o` and `trunc_err_o` are 0, and no memory request is made.
- R2: Each read index advances by one per consumed entry and wraps by masking with the ring's entry count minus one (entry counts are powers of two).
- R3: While the source ring is empty (read index equals write index) or no destination slot is posted, the engine makes no memory access and both read indices hold.
- R4: Descriptor i of a ring sits at base+2i. Word 0 holds the buffer word address. Word 1 holds the byte count in bits 15:0 and the flags in bits 31:16. The engine copies ceil(count/4) words from the source buffer to consecutive destination words, and makes no other writes besides the completion writeback.
- R5: On completion the engine writes {flags with gather bit cleared, total byte count} to word 1 of the destination descriptor. `done_o` pulses for one cycle exactly two cycles after that write, in the same cycle the destination read index shows its new value.
- R6: Flag bit 0 (gather) chains the next source descriptor into the same destination buffer, directly after the previous data. The chain yields one writeback and one `done_o` pulse, and the total is the sum of the chained counts.
- R7: A source count above `dmax_i` is clipped to `dmax_i`, only the clipped word count is copied, and `trunc_err_o` sets and stays set until reset.
- R8: Flag bit 1 (swap) reverses the bytes within every payload word that descriptor copies. Flag bits 15:8 carry a transfer id that is returned unchanged.
- R9: An entry count of zero on either ring disables the engine, and no memory access is made while pending work waits.
- R10: `src_desc_swap_i` byte-reverses both source descriptor words on fetch. `dst_desc_swap_i` byte-reverses the destination buffer address on fetch and the writeback word on store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_base_i | input | AW | Source ring base word address |
| src_entries_i | input | IDX_W+1 | Source ring entry count, power of two, 0 disables |
| src_wr_i | input | IDX_W | Source ring write index |
| src_rd_o | output | IDX_W | Current source read index |
| dst_base_i | input | AW | Destination ring base word address |
| dst_entries_i | input | IDX_W+1 | Destination ring entry count, power of two, 0 disables |
| dst_wr_i | input | IDX_W | Destination ring write index |
| dst_rd_o | output | IDX_W | Current destination read index |
| dmax_i | input | 16 | Maximum bytes accepted from one source descriptor |
| src_desc_swap_i | input | 1 | Byte-reverse source descriptor fetches |
| dst_desc_swap_i | input | 1 | Byte-reverse destination descriptor accesses |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after a read request |
| done_o | output | 1 | One-cycle copy-complete pulse |
| trunc_err_o | output | 1 | Sticky length-clip error |

## Verification
The copy path is driven with a plain single-descriptor copy, a payload-swapped word, a three-descriptor gather chain, a clipped oversized descriptor and a 6-byte count that is not a word multiple. Together these separate word counting, concatenation offsets, per-descriptor swapping and the clip. Source work is posted with no destination slot, and again with one ring disabled, to show that waiting costs no memory traffic. A run with both descriptor-swap enables set, made after the indices have wrapped, tells descriptor-format handling apart from payload handling. Every memory write is compared in order against an expected write stream built by a behavioural model.

// File: rtl/ce_pkg.sv
package ce_pkg;
  localparam int FLG_GATHER = 0;
  localparam int FLG_SWAP   = 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DCAP, ST_S0CAP, ST_S1CAP, ST_CPRD,
    ST_CPWR, ST_SADV, ST_GWAIT, ST_FIN, ST_DADV
  } ce_state_e;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/ce_ring_ptr.sv
module ce_ring_ptr #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W:0]   entries_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] mask_o
);
  logic [IDX_W:0]   ent_m1;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign ent_m1 = entries_i - 1'b1;
  assign mask_o = ent_m1[IDX_W-1:0];

  always_comb begin
    idx_d = idx_q;
    if (adv_i) idx_d = (idx_q + 1'b1) & mask_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (adv_i) idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  // R2: index moves by one and wraps by the ring mask
  assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> idx_o == (($past(idx_o) + 1'b1) & $past(mask_o)));
endmodule

// File: rtl/ce_len_clip.sv
module ce_len_clip (
  input  logic [15:0] len_i,
  input  logic [15:0] dmax_i,
  output logic [15:0] eff_o,
  output logic [15:0] words_o,
  output logic        trunc_o
);
  logic [16:0] wsum;

  always_comb begin
    trunc_o = len_i > dmax_i;
    eff_o   = trunc_o ? dmax_i : len_i;
    wsum    = ({1'b0, eff_o} + 17'd3) >> 2;
    words_o = wsum[15:0];
    // R7: accepted length never exceeds the cap
    assert_clip_R7: assert (eff_o <= dmax_i);
  end
endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine
  import ce_pkg::*;
#(
  parameter int AW    = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    src_base_i,
  input  logic [IDX_W:0]   src_entries_i,
  input  logic [IDX_W-1:0] src_wr_i,
  output logic [IDX_W-1:0] src_rd_o,
  input  logic [AW-1:0]    dst_base_i,
  input  logic [IDX_W:0]   dst_entries_i,
  input  logic [IDX_W-1:0] dst_wr_i,
  output logic [IDX_W-1:0] dst_rd_o,
  input  logic [15:0]      dmax_i,
  input  logic             src_desc_swap_i,
  input  logic             dst_desc_swap_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i,
  output logic             done_o,
  output logic             trunc_err_o
);
  ce_state_e      state_q, state_d;
  logic [AW-1:0]  dbuf_q, dbuf_d, sbuf_q, sbuf_d;
  logic [15:0]    flags_q, flags_d, eff_q, eff_d, words_q, words_d;
  logic [15:0]    cnt_q, cnt_d, woff_q, woff_d, total_q, total_d;
  logic           err_q, err_d, done_q, done_d;
  logic           src_adv, dst_adv;
  logic [IDX_W-1:0] smask, dmask;
  logic           src_en, dst_en, src_pend, dst_pend;
  logic [AW-1:0]  sdesc, ddesc;
  logic [31:0]    sw_rd, dw_rd, wb_word;
  logic [15:0]    clip_eff, clip_words;
  logic           clip_trunc;

  ce_ring_ptr #(.IDX_W(IDX_W)) u_src_ptr (
    .clk(clk), .rst_n(rst_n), .entries_i(src_entries_i), .adv_i(src_adv),
    .idx_o(src_rd_o), .mask_o(smask));
  ce_ring_ptr #(.IDX_W(IDX_W)) u_dst_ptr (
    .clk(clk), .rst_n(rst_n), .entries_i(dst_entries_i), .adv_i(dst_adv),
    .idx_o(dst_rd_o), .mask_o(dmask));

  assign sw_rd = src_desc_swap_i ? bswap32(mem_rdata_i) : mem_rdata_i;
  assign dw_rd = dst_desc_swap_i ? bswap32(mem_rdata_i) : mem_rdata_i;

  ce_len_clip u_clip (
    .len_i(sw_rd[15:0]), .dmax_i(dmax_i),
    .eff_o(clip_eff), .words_o(clip_words), .trunc_o(clip_trunc));

  assign src_en   = |src_entries_i;
  assign dst_en   = |dst_entries_i;
  assign src_pend = src_rd_o != (src_wr_i & smask);
  assign dst_pend = dst_rd_o != (dst_wr_i & dmask);
  assign sdesc    = src_base_i + (AW'(src_rd_o) << 1);
  assign ddesc    = dst_base_i + (AW'(dst_rd_o) << 1);
  assign wb_word  = {flags_q[15:1], 1'b0, total_q};

  always_comb begin
    state_d = state_q;  dbuf_d = dbuf_q;  sbuf_d = sbuf_q;
    flags_d = flags_q;  eff_d = eff_q;    words_d = words_q;
    cnt_d = cnt_q;      woff_d = woff_q;  total_d = total_q;
    err_d = err_q;      done_d = 1'b0;
    src_adv = 1'b0;     dst_adv = 1'b0;
    mem_req_o = 1'b0;   mem_we_o = 1'b0;
    mem_addr_o = '0;    mem_wdata_o = '0;
    case (state_q)
      ST_IDLE: if (src_en && dst_en && src_pend && dst_pend) begin
        mem_req_o = 1'b1; mem_addr_o = ddesc; state_d = ST_DCAP;
      end
      ST_DCAP: begin
        dbuf_d = dw_rd[AW-1:0]; woff_d = '0; total_d = '0;
        mem_req_o = 1'b1; mem_addr_o = sdesc; state_d = ST_S0CAP;
      end
      ST_S0CAP: begin
        sbuf_d = sw_rd[AW-1:0];
        mem_req_o = 1'b1; mem_addr_o = sdesc + 1'b1; state_d = ST_S1CAP;
      end
      ST_S1CAP: begin
        flags_d = sw_rd[31:16]; eff_d = clip_eff; words_d = clip_words;
        cnt_d = '0; err_d = err_q | clip_trunc;
        state_d = (clip_words == 16'd0) ? ST_SADV : ST_CPRD;
      end
      ST_CPRD: begin
        mem_req_o = 1'b1; mem_addr_o = sbuf_q + AW'(cnt_q); state_d = ST_CPWR;
      end
      ST_CPWR: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = dbuf_q + AW'(woff_q);
        mem_wdata_o = flags_q[FLG_SWAP] ? bswap32(mem_rdata_i) : mem_rdata_i;
        cnt_d = cnt_q + 16'd1; woff_d = woff_q + 16'd1;
        state_d = (cnt_q + 16'd1 == words_q) ? ST_SADV : ST_CPRD;
      end
      ST_SADV: begin
        src_adv = 1'b1; total_d = total_q + eff_q;
        state_d = flags_q[FLG_GATHER] ? ST_GWAIT : ST_FIN;
      end
      ST_GWAIT: if (src_en && src_pend) begin
        mem_req_o = 1'b1; mem_addr_o = sdesc; state_d = ST_S0CAP;
      end
      ST_FIN: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = ddesc + 1'b1;
        mem_wdata_o = dst_desc_swap_i ? bswap32(wb_word) : wb_word;
        state_d = ST_DADV;
      end
      ST_DADV: begin
        dst_adv = 1'b1; done_d = 1'b1; state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; dbuf_q <= '0; sbuf_q <= '0; flags_q <= '0;
      eff_q <= '0; words_q <= '0; cnt_q <= '0; woff_q <= '0;
      total_q <= '0; err_q <= 1'b0; done_q <= 1'b0;
    end else begin
      state_q <= state_d; dbuf_q <= dbuf_d; sbuf_q <= sbuf_d; flags_q <= flags_d;
      eff_q <= eff_d; words_q <= words_d; cnt_q <= cnt_d; woff_q <= woff_d;
      total_q <= total_d; err_q <= err_d; done_q <= done_d;
    end
  end

  assign done_o      = done_q;
  assign trunc_err_o = err_q;

  // R5: completion pulse follows the descriptor writeback by two cycles
  assert_wb_before_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(mem_we_o, 2) && $past(mem_req_o, 2)));
  // R9: a disabled ring draws no memory access from an idle engine
  assert_no_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !(src_en && dst_en)) |-> !mem_req_o);
  // R7: error flag is sticky
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trunc_err_o) |-> trunc_err_o);
endmodule

// File: tb/test_ring_copy_engine.sv
module test_ring_copy_engine;
  localparam int AW = 10, IW = 4;
  localparam int SB = 'h000, DB = 'h100, SN = 8, DN = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [AW-1:0] src_base, dst_base, mem_addr;
  logic [IW:0]   src_entries, dst_entries;
  logic [IW-1:0] src_wr, dst_wr, src_rd, dst_rd;
  logic [15:0]   dmax;
  logic          sswap, dswap, mem_req, mem_we, done, trunc_err;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [31:0]   mem [0:1023];

  ring_copy_engine #(.AW(AW), .IDX_W(IW)) i_ring_copy_engine (
    .clk(clk), .rst_n(rst_n),
    .src_base_i(src_base), .src_entries_i(src_entries), .src_wr_i(src_wr), .src_rd_o(src_rd),
    .dst_base_i(dst_base), .dst_entries_i(dst_entries), .dst_wr_i(dst_wr), .dst_rd_o(dst_rd),
    .dmax_i(dmax), .src_desc_swap_i(sswap), .dst_desc_swap_i(dswap),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .done_o(done), .trunc_err_o(trunc_err));

  always @(posedge clk) if (mem_req) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  int total = 0, bad = 0, cyc = 0, last_wr = 0;
  int exp_done = 0, done_cnt = 0, acc_cnt = 0;
  int m_post = 0, m_src = 0, d_post = 0, m_dst = 0;
  int unsigned sd_a[int], sd_l[int], sd_f[int], dd_a[int];
  int unsigned qa[$];
  logic [31:0] qd[$];
  bit wd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] bs(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
  function automatic logic [31:0] pat(input int a);
    return {16'hC0DE ^ a[15:0], a[15:0]};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  // reference stream comparison on every clock
  always @(negedge clk) if (rst_n) begin
    if (mem_req) acc_cnt++;
    if (mem_req && mem_we) begin
      total++;
      if (qa.size() == 0) begin
        bad++;
        $display("FAIL R4: write addr=%h data=%h expected no write", mem_addr, mem_wdata);
      end else begin
        if (mem_addr != qa[0][AW-1:0] || mem_wdata != qd[0]) begin
          bad++;
          $display("FAIL R4: write addr=%h data=%h expected addr=%h data=%h",
                   mem_addr, mem_wdata, qa[0][AW-1:0], qd[0]);
        end
        void'(qa.pop_front()); void'(qd.pop_front());
      end
      last_wr = cyc;
    end
    if (done) begin
      done_cnt++;
      chk("R5 done two cycles after writeback", cyc - last_wr, 2);
      chk("R5 dst index at done", {28'd0, dst_rd}, (m_dst - exp_done + done_cnt) % DN);
    end
    if (cyc > 100000 && !wd) begin
      wd = 1; total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic post_src(input int a, input int l, input int f);
    int idx = m_post % SN;
    logic [31:0] w1 = {f[15:0], l[15:0]};
    sd_a[m_post] = a; sd_l[m_post] = l; sd_f[m_post] = f;
    mem[SB + 2*idx]     = sswap ? bs(a) : a;
    mem[SB + 2*idx + 1] = sswap ? bs(w1) : w1;
    m_post++;
    src_wr = IW'(m_post % SN);
  endtask

  task automatic post_dst(input int a);
    int idx = d_post % DN;
    dd_a[d_post] = a;
    mem[DB + 2*idx]     = dswap ? bs(a) : a;
    mem[DB + 2*idx + 1] = 32'd0;
    d_post++;
    dst_wr = IW'(d_post % DN);
  endtask

  // behavioural model of one complete destination transfer
  task automatic model();
    int dbuf = dd_a[m_dst], woff = 0, tot = 0, f, eff;
    logic [31:0] wb;
    do begin
      f   = sd_f[m_src];
      eff = (sd_l[m_src] > dmax) ? dmax : sd_l[m_src];
      for (int k = 0; k < (eff + 3) / 4; k++) begin
        logic [31:0] d = mem[sd_a[m_src] + k];
        qa.push_back(dbuf + woff);
        qd.push_back((f & 2) ? bs(d) : d);
        woff++;
      end
      tot += eff;
      m_src++;
    end while (f & 1);
    wb = {f[15:1], 1'b0, tot[15:0]};
    qa.push_back(DB + 2*(m_dst % DN) + 1);
    qd.push_back(dswap ? bs(wb) : wb);
    m_dst++;
    exp_done++;
  endtask

  task automatic wait_done(input string r);
    while (done_cnt < exp_done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk({r, " write stream drained"}, qa.size(), 0);
    chk("R2 src read index", {28'd0, src_rd}, m_src % SN);
    chk("R2 dst read index", {28'd0, dst_rd}, m_dst % DN);
  endtask

  initial begin
    int a0;
    rst_n = 1'b0; src_base = SB; dst_base = DB; src_entries = SN; dst_entries = DN;
    src_wr = '0; dst_wr = '0; dmax = 16'hFFFF; sswap = 1'b0; dswap = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = (i >= 'h200 && i < 'h300) ? pat(i) : 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    chk("R1 src_rd reset", {28'd0, src_rd}, 0);
    chk("R1 dst_rd reset", {28'd0, dst_rd}, 0);
    chk("R1 done reset", {31'd0, done}, 0);
    chk("R1 err reset", {31'd0, trunc_err}, 0);
    chk("R1 no request", {31'd0, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: plain copy, transfer id 5
    post_dst('h300); post_src('h200, 8, 'h0500); model(); wait_done("R4");
    chk("R4 first word copied", mem['h300], pat('h200));
    chk("R7 no error on short copy", {31'd0, trunc_err}, 0);

    // R8: payload swap, id 3
    post_dst('h310); post_src('h210, 4, 'h0302); model(); wait_done("R8");
    chk("R8 swapped word", mem['h310], bs(pat('h210)));

    // R6: gather chain of three descriptors
    a0 = done_cnt;
    post_dst('h320);
    post_src('h220, 4, 1); post_src('h230, 8, 1); post_src('h240, 4, 'h0700);
    model(); wait_done("R6");
    chk("R6 single completion", done_cnt - a0, 1);
    chk("R6 concatenated word", mem['h322], pat('h231));
    chk("R6 total in writeback", mem[DB + 2*2 + 1], 32'h0700_0010);

    // R7: clip to dmax
    dmax = 16'd8;
    post_dst('h330); post_src('h250, 20, 0); model(); wait_done("R7");
    chk("R7 err set", {31'd0, trunc_err}, 1);
    chk("R7 word beyond cap untouched", mem['h332], 32'hDEADBEEF);
    dmax = 16'hFFFF;

    // R3: no destination slot, 6-byte count
    post_src('h260, 6, 0);
    a0 = acc_cnt;
    repeat (40) @(negedge clk);
    chk("R3 no access without slot", acc_cnt - a0, 0);
    chk("R3 src index holds", {28'd0, src_rd}, m_src % SN);
    post_dst('h340); model(); wait_done("R3");
    chk("R7 err stays set", {31'd0, trunc_err}, 1);

    // R9: disabled source ring
    src_entries = '0;
    post_dst('h350); post_src('h270, 4, 0);
    a0 = acc_cnt;
    repeat (40) @(negedge clk);
    chk("R9 no access while disabled", acc_cnt - a0, 0);
    src_entries = SN;
    model(); wait_done("R9");
    chk("R2 dst index wrapped", {28'd0, dst_rd}, 2);

    // R10: descriptor swap on both rings, source index wraps here
    sswap = 1'b1; dswap = 1'b1;
    post_dst('h360); post_src('h280, 8, 'h0900); model(); wait_done("R10");
    chk("R10 data at fetched address", mem['h361], pat('h281));
    chk("R10 swapped writeback", mem[DB + 2*(6 % DN) + 1], bs(32'h0900_0008));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule